// File: doc/BRIEF.md
# SPI FIFO Interrupt and DMA Request Unit

This block sits beside the transmit and receive FIFOs of a serial peripheral controller. It watches their fill levels and push/pop traffic and turns them into one combined interrupt line and two DMA request lines. It does not contain the FIFOs or the shift engine. It keeps a small set of registers: level thresholds for the interrupt sources, separate watermarks for the DMA requests, an interrupt mask, a DMA enable word and a write-one-to-clear port. It also offers readable raw status, masked status and a FIFO status word.

Software programs the thresholds and watermarks while the controller is disabled, then sets the controller enable. From that point the thresholds are frozen. Level-based sources follow the FIFO levels. Error sources latch until software clears them. The interrupt line is the OR of every unmasked source.

Top module: `spi_irq_dma_unit`

## Requirements
- R1: After synchronous reset, `irq`, `tx_dreq` and `rx_dreq` are 0, and every writable register reads 0. Register addresses are: 0 tx threshold, 1 rx threshold, 2 mask, 3 clear (write only), 4 DMA enable, 5 tx DMA watermark, 6 rx DMA watermark, 7 raw status, 8 masked status, 9 FIFO status. Unused read bits are 0.
- R2: Raw status bit 0 (transmit low) is 1 while `tx_level` is less than or equal to the tx threshold. It is visible one cycle after the inputs change.
- R3: Raw status bit 4 (receive high) is 1 only when `rx_level` is strictly greater than the rx threshold, that is, at least threshold plus one.
- R4: A push into a full transmit FIFO sets raw bit 1. A pop from an empty receive FIFO sets raw bit 2. A push into a full receive FIFO sets raw bit 3. Each bit stays set until it is cleared. A push or pop that finds its FIFO not full or not empty sets nothing.
- R5: A `cs_inact` pulse sets raw bit 6, which stays set until it is cleared.
- R6: Writing the clear register works as follows: bit 0 clears every sticky bit (1, 2, 3, 6); bit 1 clears bit 2; bit 2 clears bit 3; bit 3 clears bit 1. Bits written 0 leave their sources unchanged. If a set and a clear land in the same cycle, the set wins.
- R7: Masked status equals raw status AND the mask register. `irq` is the OR of the masked bits, registered one cycle after masked status.
- R8: While `ctrl_en` is 1, writes to the four threshold and watermark registers are ignored. Writes to the mask and DMA enable registers are always accepted.
- R9: `tx_dreq` is 1 one cycle after DMA enable bit 1 is set and `tx_level` is at or below the tx watermark.
- R10: `rx_dreq` is 1 one cycle after DMA enable bit 0 is set and `rx_level` is at least the rx watermark plus one.
- R11: The FIFO status word is laid out as follows: bit 0 `busy`, bit 1 tx full, bit 2 tx empty, bit 3 rx empty, bit 4 rx full, bit 5 `slv_tx_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_en | input | 1 | Controller enabled; locks thresholds |
| busy | input | 1 | Serial engine busy |
| slv_tx_busy | input | 1 | Slave-mode transmit busy |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_push | input | 1 | Transmit FIFO push strobe |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_pop | input | 1 | Receive FIFO pop strobe |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| cs_inact | input | 1 | Chip-select-inactive event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DW | Registered read data |
| irq | output | 1 | Combined interrupt |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |

## Verification
The hardest case to reach is a set and a clear of the same sticky source meeting in one cycle, together with the rule that only the selected sources clear. The bench builds up several error bits with isolated strobes that coincide with full or empty flags. It then clears them one selector at a time and reads raw status after each write. The threshold lock needs the enable raised with a known value already stored. The bench then writes a different value and reads back the old one, while a mask write in the same window still takes effect.

// File: rtl/sidu_pkg.sv
package sidu_pkg;
  typedef enum logic [3:0] {
    A_TXTHR  = 4'd0,
    A_RXTHR  = 4'd1,
    A_MASK   = 4'd2,
    A_CLR    = 4'd3,
    A_DMACTL = 4'd4,
    A_TXWM   = 4'd5,
    A_RXWM   = 4'd6,
    A_RAW    = 4'd7,
    A_MSTAT  = 4'd8,
    A_STAT   = 4'd9
  } sidu_addr_e;

  localparam int IRQ_W    = 7;
  localparam int B_TXLOW  = 0;
  localparam int B_TXOVF  = 1;
  localparam int B_RXUNF  = 2;
  localparam int B_RXOVF  = 3;
  localparam int B_RXHIGH = 4;
  localparam int B_CSOFF  = 6;

  localparam int STAT_W   = 6;
  localparam int N_LIMIT  = 4;

  function automatic logic [3:0] limit_addr(input int idx);
    case (idx)
      0:       limit_addr = A_TXTHR;
      1:       limit_addr = A_RXTHR;
      2:       limit_addr = A_TXWM;
      default: limit_addr = A_RXWM;
    endcase
  endfunction
endpackage

// File: rtl/sidu_cfg.sv
module sidu_cfg
  import sidu_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_en,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [LVL_W-1:0] tx_thr,
  output logic [LVL_W-1:0] rx_thr,
  output logic [LVL_W-1:0] tx_wm,
  output logic [LVL_W-1:0] rx_wm,
  output logic [IRQ_W-1:0] irq_mask,
  output logic [1:0]       dma_ctl,
  output logic [3:0]       clr_req
);
  logic [LVL_W-1:0] lim_q [N_LIMIT];

  for (genvar gi = 0; gi < N_LIMIT; gi++) begin : g_lim
    always_ff @(posedge clk) begin
      if (rst)
        lim_q[gi] <= '0;
      else if (wr_en && !ctrl_en && wr_addr == limit_addr(gi))
        lim_q[gi] <= wr_data[LVL_W-1:0];
    end
  end

  assign tx_thr = lim_q[0];
  assign rx_thr = lim_q[1];
  assign tx_wm  = lim_q[2];
  assign rx_wm  = lim_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_mask <= '0;
      dma_ctl  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MASK)   irq_mask <= wr_data[IRQ_W-1:0];
      if (wr_addr == A_DMACTL) dma_ctl  <= wr_data[1:0];
    end
  end

  assign clr_req = (wr_en && wr_addr == A_CLR) ? wr_data[3:0] : 4'b0000;
endmodule

// File: rtl/sidu_irq.sv
module sidu_irq
  import sidu_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic             tx_push,
  input  logic             tx_full,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             rx_full,
  input  logic             rx_empty,
  input  logic             cs_inact,
  input  logic [3:0]       clr_req,
  input  logic [IRQ_W-1:0] irq_mask,
  output logic [IRQ_W-1:0] raw_stat,
  output logic [IRQ_W-1:0] msk_stat,
  output logic             irq
);
  logic [LVL_W:0]   rx_thr_p1;
  logic [IRQ_W-1:0] set_vec;
  logic [IRQ_W-1:0] clr_vec;
  logic [IRQ_W-1:0] sticky;

  assign rx_thr_p1 = {1'b0, rx_thr} + {{LVL_W{1'b0}}, 1'b1};

  always_comb begin
    set_vec = '0;
    set_vec[B_TXOVF] = tx_push & tx_full;
    set_vec[B_RXUNF] = rx_pop  & rx_empty;
    set_vec[B_RXOVF] = rx_push & rx_full;
    set_vec[B_CSOFF] = cs_inact;
    clr_vec = '0;
    clr_vec[B_RXUNF] = clr_req[0] | clr_req[1];
    clr_vec[B_RXOVF] = clr_req[0] | clr_req[2];
    clr_vec[B_TXOVF] = clr_req[0] | clr_req[3];
    clr_vec[B_CSOFF] = clr_req[0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      sticky <= '0;
    else
      sticky <= set_vec | (sticky & ~clr_vec);
  end

  logic tx_low_q, rx_high_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_low_q  <= 1'b0;
      rx_high_q <= 1'b0;
    end else begin
      tx_low_q  <= (tx_level <= tx_thr);
      rx_high_q <= ({1'b0, rx_level} >= rx_thr_p1);
    end
  end

  always_comb begin
    raw_stat = sticky;
    raw_stat[B_TXLOW]  = tx_low_q;
    raw_stat[B_RXHIGH] = rx_high_q;
  end

  assign msk_stat = raw_stat & irq_mask;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |msk_stat;
  end
endmodule

// File: rtl/sidu_dreq.sv
module sidu_dreq #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       dma_ctl,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_wm,
  input  logic [LVL_W-1:0] rx_wm,
  output logic             tx_dreq,
  output logic             rx_dreq
);
  logic [LVL_W:0] rx_wm_p1;
  assign rx_wm_p1 = {1'b0, rx_wm} + {{LVL_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_dreq <= 1'b0;
      rx_dreq <= 1'b0;
    end else begin
      tx_dreq <= dma_ctl[1] && (tx_level <= tx_wm);
      rx_dreq <= dma_ctl[0] && ({1'b0, rx_level} >= rx_wm_p1);
    end
  end
endmodule

// File: rtl/sidu_stat.sv
module sidu_stat
  import sidu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic              slv_tx_busy,
  output logic [STAT_W-1:0] fifo_stat
);
  always_ff @(posedge clk) begin
    if (rst) fifo_stat <= '0;
    else     fifo_stat <= {slv_tx_busy, rx_full, rx_empty, tx_empty, tx_full, busy};
  end
endmodule

// File: rtl/spi_irq_dma_unit.sv
module spi_irq_dma_unit
  import sidu_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_en,
  input  logic             busy,
  input  logic             slv_tx_busy,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_push,
  input  logic             tx_full,
  input  logic             tx_empty,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             rx_full,
  input  logic             rx_empty,
  input  logic             cs_inact,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [3:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             irq,
  output logic             tx_dreq,
  output logic             rx_dreq
);
  logic [LVL_W-1:0]  tx_thr, rx_thr, tx_wm, rx_wm;
  logic [IRQ_W-1:0]  irq_mask, raw_stat, msk_stat;
  logic [1:0]        dma_ctl;
  logic [3:0]        clr_req;
  logic [STAT_W-1:0] fifo_stat;

  sidu_cfg #(.LVL_W(LVL_W), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_wm(tx_wm), .rx_wm(rx_wm),
    .irq_mask(irq_mask), .dma_ctl(dma_ctl), .clr_req(clr_req)
  );

  sidu_irq #(.LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst(rst),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_push(tx_push), .tx_full(tx_full),
    .rx_push(rx_push), .rx_pop(rx_pop),
    .rx_full(rx_full), .rx_empty(rx_empty),
    .cs_inact(cs_inact), .clr_req(clr_req), .irq_mask(irq_mask),
    .raw_stat(raw_stat), .msk_stat(msk_stat), .irq(irq)
  );

  sidu_dreq #(.LVL_W(LVL_W)) u_dreq (
    .clk(clk), .rst(rst), .dma_ctl(dma_ctl),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_wm(tx_wm), .rx_wm(rx_wm),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
  );

  sidu_stat u_stat (
    .clk(clk), .rst(rst), .busy(busy),
    .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_empty(rx_empty), .rx_full(rx_full),
    .slv_tx_busy(slv_tx_busy), .fifo_stat(fifo_stat)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_TXTHR:  rd_mux[LVL_W-1:0]  = tx_thr;
      A_RXTHR:  rd_mux[LVL_W-1:0]  = rx_thr;
      A_MASK:   rd_mux[IRQ_W-1:0]  = irq_mask;
      A_DMACTL: rd_mux[1:0]        = dma_ctl;
      A_TXWM:   rd_mux[LVL_W-1:0]  = tx_wm;
      A_RXWM:   rd_mux[LVL_W-1:0]  = rx_wm;
      A_RAW:    rd_mux[IRQ_W-1:0]  = raw_stat;
      A_MSTAT:  rd_mux[IRQ_W-1:0]  = msk_stat;
      A_STAT:   rd_mux[STAT_W-1:0] = fifo_stat;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/sidu_checker.sv
module sidu_checker
  import sidu_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_en,
  input logic             wr_en,
  input logic [3:0]       wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_push,
  input logic             tx_full,
  input logic             cs_inact,
  input logic             irq,
  input logic             tx_dreq,
  input logic             rx_dreq,
  input logic [LVL_W-1:0] tx_thr,
  input logic [LVL_W-1:0] tx_wm,
  input logic [LVL_W-1:0] rx_wm,
  input logic [IRQ_W-1:0] irq_mask,
  input logic [1:0]       dma_ctl,
  input logic [IRQ_W-1:0] raw_stat
);
  logic clr_txovf;
  assign clr_txovf = wr_en && (wr_addr == A_CLR) && (wr_data[0] || wr_data[3]);

  assert_ovf_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_push && tx_full) |=> raw_stat[B_TXOVF]);

  assert_ovf_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (raw_stat[B_TXOVF] && !clr_txovf) |=> raw_stat[B_TXOVF]);

  assert_cs_event_R5: assert property (@(posedge clk) disable iff (rst)
    cs_inact |=> raw_stat[B_CSOFF]);

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (|(raw_stat & irq_mask)) |=> irq);

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !(|(raw_stat & irq_mask)) |=> !irq);

  assert_thr_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && wr_en && wr_addr == A_TXTHR) |=> $stable(tx_thr));

  assert_txdreq_on_R9: assert property (@(posedge clk) disable iff (rst)
    (dma_ctl[1] && tx_level <= tx_wm) |=> tx_dreq);

  assert_txdreq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !dma_ctl[1] |=> !tx_dreq);

  assert_rxdreq_on_R10: assert property (@(posedge clk) disable iff (rst)
    (dma_ctl[0] && rx_level > rx_wm) |=> rx_dreq);

  assert_rxdreq_off_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_level <= rx_wm) |=> !rx_dreq);
endmodule

bind spi_irq_dma_unit sidu_checker #(.LVL_W(LVL_W), .DW(DW)) u_sidu_chk (
  .clk(clk), .rst(rst), .ctrl_en(ctrl_en),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tx_level(tx_level), .rx_level(rx_level),
  .tx_push(tx_push), .tx_full(tx_full), .cs_inact(cs_inact),
  .irq(irq), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
  .tx_thr(tx_thr), .tx_wm(tx_wm), .rx_wm(rx_wm),
  .irq_mask(irq_mask), .dma_ctl(dma_ctl), .raw_stat(raw_stat)
);

// File: tb/spi_irq_dma_unit_bench.sv
module spi_irq_dma_unit_bench;
  localparam int DEPTH = 32;
  localparam int DW    = 32;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_en = 0, busy = 0, slv_tx_busy = 0;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic tx_push = 0, tx_full = 0, tx_empty = 0;
  logic rx_push = 0, rx_pop = 0, rx_full = 0, rx_empty = 0, cs_inact = 0;
  logic wr_en = 0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic irq, tx_dreq, rx_dreq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  spi_irq_dma_unit #(.DEPTH(DEPTH), .DW(DW)) u_spi_irq_dma_unit (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .busy(busy), .slv_tx_busy(slv_tx_busy),
    .tx_level(tx_level), .tx_push(tx_push), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full),
    .rx_empty(rx_empty), .cs_inact(cs_inact), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO-unit FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    settle();
    d = rd_data;
  endtask

  task automatic pulse(ref logic s);
    s = 1;
    @(negedge clk);
    s = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_dreq", {31'b0, tx_dreq}, 0);
    chk("R1 rx_dreq", {31'b0, rx_dreq}, 0);
    rd(4'd2, d); chk("R1 mask", d, 0);
    rd(4'd0, d); chk("R1 txthr", d, 0);
    rd(4'd4, d); chk("R1 dmactl", d, 0);
    rd(4'd7, d); chk("R1 raw (only tx low)", d, 32'h01);
  endtask

  task automatic t_tx_low();
    logic [31:0] d;
    wr(4'd0, 4);
    tx_level = 4; rd(4'd7, d); chk("R2 tx at thr", d & 32'h1, 1);
    tx_level = 5; rd(4'd7, d); chk("R2 tx above thr", d & 32'h1, 0);
    tx_level = 0;
  endtask

  task automatic t_rx_high();
    logic [31:0] d;
    wr(4'd1, 3);
    rx_level = 3; rd(4'd7, d); chk("R3 rx equal thr", d & 32'h10, 0);
    rx_level = 4; rd(4'd7, d); chk("R3 rx thr+1", d & 32'h10, 32'h10);
    rx_level = 0;
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(tx_push); pulse(rx_pop); pulse(rx_push);
    rd(4'd7, d); chk("R4 no set when not full/empty", d & 32'h4E, 0);
    tx_full = 1; pulse(tx_push); tx_full = 0;
    rx_empty = 1; pulse(rx_pop); rx_empty = 0;
    rx_full = 1; pulse(rx_push); rx_full = 0;
    repeat (5) @(negedge clk);
    rd(4'd7, d); chk("R4 sticky set", d & 32'h4E, 32'h0E);
  endtask

  task automatic t_cs();
    logic [31:0] d;
    pulse(cs_inact);
    repeat (4) @(negedge clk);
    rd(4'd7, d); chk("R5 cs inactive sticky", d & 32'h40, 32'h40);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(4'd3, 32'h2); rd(4'd7, d); chk("R6 sel1 clears bit2", d & 32'h4E, 32'h4A);
    wr(4'd3, 32'h8); rd(4'd7, d); chk("R6 sel3 clears bit1", d & 32'h4E, 32'h48);
    wr(4'd3, 32'h4); rd(4'd7, d); chk("R6 sel2 clears bit3", d & 32'h4E, 32'h40);
    tx_full = 1; pulse(tx_push); tx_full = 0;
    wr(4'd3, 32'h1); rd(4'd7, d); chk("R6 sel0 clears all", d & 32'h4E, 0);
    tx_full = 1; tx_push = 1; wr(4'd3, 32'h8); tx_push = 0; tx_full = 0;
    rd(4'd7, d); chk("R6 set beats clear", d & 32'h02, 32'h02);
    wr(4'd3, 32'h1);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(4'd2, 32'h01); settle();
    chk("R7 irq unmasked", {31'b0, irq}, 1);
    rd(4'd8, d); chk("R7 masked stat", d, 32'h01);
    wr(4'd2, 32'h10); settle();
    chk("R7 irq masked out", {31'b0, irq}, 0);
    rd(4'd8, d); chk("R7 masked stat zero", d, 0);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    ctrl_en = 1;
    wr(4'd0, 9); wr(4'd5, 7);
    rd(4'd0, d); chk("R8 txthr locked", d, 4);
    rd(4'd5, d); chk("R8 txwm locked", d, 0);
    wr(4'd2, 32'h20); rd(4'd2, d); chk("R8 mask still writable", d, 32'h20);
    wr(4'd2, 0);
    ctrl_en = 0;
  endtask

  task automatic t_txdma();
    wr(4'd5, 6); wr(4'd4, 2);
    tx_level = 6; settle(); chk("R9 tx at wm", {31'b0, tx_dreq}, 1);
    tx_level = 7; settle(); chk("R9 tx above wm", {31'b0, tx_dreq}, 0);
    tx_level = 1; wr(4'd4, 0); settle(); chk("R9 disabled", {31'b0, tx_dreq}, 0);
    tx_level = 0;
  endtask

  task automatic t_rxdma();
    wr(4'd6, 2); wr(4'd4, 1);
    rx_level = 2; settle(); chk("R10 rx at wm", {31'b0, rx_dreq}, 0);
    rx_level = 3; settle(); chk("R10 rx wm+1", {31'b0, rx_dreq}, 1);
    wr(4'd4, 0); settle(); chk("R10 disabled", {31'b0, rx_dreq}, 0);
    rx_level = 0;
  endtask

  task automatic t_status();
    logic [31:0] d;
    busy = 1; tx_full = 1; rx_empty = 1; slv_tx_busy = 1;
    rd(4'd9, d); chk("R11 status A", d, 32'h2B);
    busy = 0; tx_full = 0; rx_empty = 0; slv_tx_busy = 0;
    tx_empty = 1; rx_full = 1;
    rd(4'd9, d); chk("R11 status B", d, 32'h14);
    tx_empty = 0; rx_full = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FIFO-unit FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_tx_low();
    t_rx_high();
    t_sticky();
    t_cs();
    t_clear();
    t_mask();
    t_lock();
    t_txdma();
    t_rxdma();
    t_status();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule